// File: doc/BRIEF.md
# Sector Write Guard

The sector write guard decides, for each program or erase request, whether the addressed sector may be changed. Each sector carries two guard bits: a volatile dynamic bit and a persistent bit. A bit value of 0 means "protected" and 1 means "unprotected". A sector is writable only when both of its bits read 1.

The host changes and reads these bits through decoded commands. Each command is presented for one cycle with a sector index and, where it applies, a data bit. A single freeze flag, called the lock, guards the persistent bits.
- Clearing the lock through a command freezes the persistent bits until the next power-on reset.
- In persistent mode the lock comes up set at power-on.
- In password mode the lock comes up clear, and only an unlock command that arrives with a matching password result sets it.
- A software reset puts every dynamic bit back to unprotected. It leaves the persistent bits and the lock as they are.

Writes to the non-volatile bits are modelled as single-cycle updates. On power-on, the non-volatile store is initialised to all sectors unprotected. Command and request inputs are plain one-cycle strobes with no back-pressure: the block accepts one of each on every cycle, so the host never waits.

Top module: `spu_sector_guard`

## Requirements
- R1: A request (`req_valid`, `req_sector`) is answered one cycle later.
  - The answer is a one-cycle `req_grant` pulse when the sector's dynamic bit and persistent bit are both 1.
  - Otherwise the answer is a one-cycle `req_err` pulse.
  - The two pulses are never high together.
- R2: Opcode 0xE1 writes `cmd_wdata` into the dynamic bit of `cmd_sector`. Opcode 0xE0 reads that bit back.
- R3: Opcode 0xE3 clears only the persistent bit of `cmd_sector` to 0. Opcode 0xE2 reads a persistent bit back.
- R4: Opcode 0xE4 sets every persistent bit to 1 in one cycle.
- R5: While the lock is 0, the opcodes 0xE3 and 0xE4 leave every persistent bit unchanged.
- R6: Opcode 0xA6 clears the lock to 0, and opcode 0xA7 reads it.
  - Once the lock has been cleared, no command sets it again before the next power-on reset.
  - This includes a password unlock that arrives with a match.
- R7: Lock state at power-on reset depends on `pwd_mode`.
  - With `pwd_mode` low (persistent mode), the lock is 1.
  - With `pwd_mode` high (password mode), the lock is 0 and becomes 1 only on opcode 0xE9 with `pwd_match` high.
  - Opcode 0xE9 with `pwd_match` low has no effect.
- R8: While `sw_rst` is high, every dynamic bit returns to 1 on the next edge. The lock and the persistent bits stay unchanged, and a command presented in that same cycle is ignored.
- R9: After power-on reset, every dynamic bit and every persistent bit reads 1.
- R10: A read command (0xE0, 0xE2, 0xA7) produces a `rd_valid` pulse with `rd_bit` one cycle later. Any other opcode produces no read response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pwd_mode | input | 1 | Lock mode strap: 0 persistent, 1 password |
| sw_rst | input | 1 | Software reset strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_sector | input | SEC_W | Sector index for the command |
| cmd_wdata | input | 1 | Data bit for a dynamic write |
| pwd_match | input | 1 | Password compare result for an unlock |
| req_valid | input | 1 | Program/erase permission request strobe |
| req_sector | input | SEC_W | Sector index of the request |
| req_grant | output | 1 | One-cycle pulse: request allowed |
| req_err | output | 1 | One-cycle pulse: request refused |
| rd_valid | output | 1 | Read response strobe |
| rd_bit | output | 1 | Bit returned by a read command |

## Verification
Every result is registered once, so read responses and request verdicts are due exactly one cycle after the strobe that caused them. State changes from commands and resets are visible to the very next read or request. The bench drives inputs on the falling edge. It places each expected response in a queue at that moment. The monitor compares the outputs on the following falling edge, so a result that arrives early, late or without a cause is seen as an empty-queue mismatch or a leftover item.

// File: rtl/spu_pkg.sv
package spu_pkg;
  localparam logic [7:0] OP_DYN_RD  = 8'hE0;
  localparam logic [7:0] OP_DYN_WR  = 8'hE1;
  localparam logic [7:0] OP_PER_RD  = 8'hE2;
  localparam logic [7:0] OP_PER_CLR = 8'hE3;
  localparam logic [7:0] OP_PER_SET = 8'hE4;
  localparam logic [7:0] OP_LCK_RD  = 8'hA7;
  localparam logic [7:0] OP_LCK_CLR = 8'hA6;
  localparam logic [7:0] OP_UNLOCK  = 8'hE9;
endpackage

// File: rtl/spu_dyn_bank.sv
module spu_dyn_bank #(
  parameter int NUM_SECTORS = 16,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   clr_all,
  input  logic                   wr_en,
  input  logic [SEC_W-1:0]       wr_idx,
  input  logic                   wr_val,
  output logic [NUM_SECTORS-1:0] bits
);
  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                  bits[s] <= 1'b1;
      else if (clr_all)                            bits[s] <= 1'b1;
      else if (wr_en && wr_idx == SEC_W'(s))       bits[s] <= wr_val;
    end
  end
endmodule

// File: rtl/spu_per_bank.sv
module spu_per_bank #(
  parameter int NUM_SECTORS = 16,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   clr_en,
  input  logic [SEC_W-1:0]       clr_idx,
  input  logic                   set_all,
  output logic [NUM_SECTORS-1:0] bits
);
  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                  bits[s] <= 1'b1;
      else if (set_all)                            bits[s] <= 1'b1;
      else if (clr_en && clr_idx == SEC_W'(s))     bits[s] <= 1'b0;
    end
  end
endmodule

// File: rtl/spu_lock.sv
module spu_lock (
  input  logic clk,
  input  logic por_n,
  input  logic pwd_mode,
  input  logic clr_req,
  input  logic unlock_req,
  input  logic pwd_match,
  output logic lock
);
  logic frozen;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock   <= !pwd_mode;
      frozen <= 1'b0;
    end else if (clr_req) begin
      lock   <= 1'b0;
      frozen <= 1'b1;
    end else if (unlock_req && pwd_mode && pwd_match && !frozen) begin
      lock   <= 1'b1;
    end
  end
endmodule

// File: rtl/spu_sector_guard.sv
module spu_sector_guard #(
  parameter int NUM_SECTORS = 16,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pwd_mode,
  input  logic             sw_rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [SEC_W-1:0] cmd_sector,
  input  logic             cmd_wdata,
  input  logic             pwd_match,
  input  logic             req_valid,
  input  logic [SEC_W-1:0] req_sector,
  output logic             req_grant,
  output logic             req_err,
  output logic             rd_valid,
  output logic             rd_bit
);
  import spu_pkg::*;

  logic [NUM_SECTORS-1:0] dyn_q, ppb_q;
  logic lock_q;
  logic go, sec_ok;
  logic dyn_wr, per_clr, per_set, lck_clr, unlock;
  logic is_rd, rd_val;

  assign go     = cmd_valid && !sw_rst;
  assign sec_ok = 32'(cmd_sector) < NUM_SECTORS;

  always_comb begin
    dyn_wr  = 1'b0;
    per_clr = 1'b0;
    per_set = 1'b0;
    lck_clr = 1'b0;
    unlock  = 1'b0;
    is_rd   = 1'b0;
    rd_val  = 1'b0;
    if (go) begin
      unique case (cmd_op)
        OP_DYN_WR:  dyn_wr  = sec_ok;
        OP_PER_CLR: per_clr = sec_ok && lock_q;
        OP_PER_SET: per_set = lock_q;
        OP_LCK_CLR: lck_clr = 1'b1;
        OP_UNLOCK:  unlock  = 1'b1;
        OP_DYN_RD: begin
          is_rd  = 1'b1;
          rd_val = sec_ok && dyn_q[cmd_sector];
        end
        OP_PER_RD: begin
          is_rd  = 1'b1;
          rd_val = sec_ok && ppb_q[cmd_sector];
        end
        OP_LCK_RD: begin
          is_rd  = 1'b1;
          rd_val = lock_q;
        end
        default: ;
      endcase
    end
  end

  spu_dyn_bank #(.NUM_SECTORS(NUM_SECTORS)) u_dyn (
    .clk(clk), .por_n(por_n), .clr_all(sw_rst), .wr_en(dyn_wr),
    .wr_idx(cmd_sector), .wr_val(cmd_wdata), .bits(dyn_q));

  spu_per_bank #(.NUM_SECTORS(NUM_SECTORS)) u_per (
    .clk(clk), .por_n(por_n), .clr_en(per_clr), .clr_idx(cmd_sector),
    .set_all(per_set), .bits(ppb_q));

  spu_lock u_lock (
    .clk(clk), .por_n(por_n), .pwd_mode(pwd_mode), .clr_req(lck_clr),
    .unlock_req(unlock), .pwd_match(pwd_match), .lock(lock_q));

  logic open_sec;
  assign open_sec = (32'(req_sector) < NUM_SECTORS) &&
                    dyn_q[req_sector] && ppb_q[req_sector];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      req_grant <= 1'b0;
      req_err   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_bit    <= 1'b0;
    end else begin
      req_grant <= req_valid && open_sec;
      req_err   <= req_valid && !open_sec;
      rd_valid  <= is_rd;
      rd_bit    <= is_rd && rd_val;
    end
  end
endmodule

// File: rtl/spu_guard_checker.sv
module spu_guard_checker #(
  parameter int NUM_SECTORS = 16
) (
  input logic                   clk,
  input logic                   por_n,
  input logic                   pwd_mode,
  input logic                   sw_rst,
  input logic                   cmd_valid,
  input logic [7:0]             cmd_op,
  input logic                   pwd_match,
  input logic                   req_valid,
  input logic                   req_grant,
  input logic                   req_err,
  input logic                   rd_valid,
  input logic                   lock_q,
  input logic [NUM_SECTORS-1:0] dyn_q,
  input logic [NUM_SECTORS-1:0] ppb_q
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!por_n)
    !(req_grant && req_err)); // R1
  AST_VERDICT_HAS_REQ: assert property (@(posedge clk) disable iff (!por_n)
    (req_grant || req_err) |-> $past(req_valid)); // R1
  AST_SWRST_DYN_OPEN: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> (dyn_q == {NUM_SECTORS{1'b1}})); // R8
  AST_SWRST_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> $stable(lock_q)); // R8
  AST_FROZEN_PER: assert property (@(posedge clk) disable iff (!por_n)
    !lock_q |=> $stable(ppb_q)); // R5
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!por_n)
    (!lock_q && !(cmd_valid && !sw_rst && cmd_op == 8'hE9 && pwd_match && pwd_mode))
    |=> !lock_q); // R7
  AST_READ_HAS_CMD: assert property (@(posedge clk) disable iff (!por_n)
    rd_valid |-> $past(cmd_valid)); // R10
endmodule

bind spu_sector_guard spu_guard_checker #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
  .clk(clk), .por_n(por_n), .pwd_mode(pwd_mode), .sw_rst(sw_rst),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .pwd_match(pwd_match),
  .req_valid(req_valid), .req_grant(req_grant), .req_err(req_err),
  .rd_valid(rd_valid), .lock_q(lock_q), .dyn_q(dyn_q), .ppb_q(ppb_q));

// File: tb/spu_sector_guard_test.sv
`timescale 1ns/1ps
module spu_sector_guard_test;
  localparam int N = 16;
  localparam int SW = $clog2(N);

  logic clk = 1'b0, por_n = 1'b0, pwd_mode = 1'b0, sw_rst = 1'b0;
  logic cmd_valid = 1'b0, cmd_wdata = 1'b0, pwd_match = 1'b0, req_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [SW-1:0] cmd_sector = '0, req_sector = '0;
  logic req_grant, req_err, rd_valid, rd_bit;

  always #2.5 clk = ~clk;

  spu_sector_guard #(.NUM_SECTORS(N)) uut (
    .clk(clk), .por_n(por_n), .pwd_mode(pwd_mode), .sw_rst(sw_rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sector(cmd_sector),
    .cmd_wdata(cmd_wdata), .pwd_match(pwd_match), .req_valid(req_valid),
    .req_sector(req_sector), .req_grant(req_grant), .req_err(req_err),
    .rd_valid(rd_valid), .rd_bit(rd_bit));

  int n_chk = 0, n_bad = 0;
  bit    rd_q[$];  string rd_tag[$];
  bit    vq[$];    string vq_tag[$];
  bit m_dyn[N], m_per[N];
  bit m_lock, m_frz;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (por_n) begin
      if (rd_valid) begin
        if (rd_q.size() == 0) check(1'b0, "R10 unexpected read", 1, 0);
        else begin
          automatic bit e = rd_q.pop_front();
          automatic string t = rd_tag.pop_front();
          check(rd_bit == e, t, rd_bit, e);
        end
      end
      if (req_grant || req_err) begin
        if (vq.size() == 0) check(1'b0, "R1 unexpected verdict", 1, 0);
        else begin
          automatic bit g = vq.pop_front();
          automatic string t = vq_tag.pop_front();
          check(req_grant == g && req_err == !g, t, {req_grant, req_err}, {g, !g});
        end
      end
    end
  end

  task automatic power_on(input bit pm);
    @(negedge clk);
    pwd_mode = pm; por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    foreach (m_dyn[i]) begin m_dyn[i] = 1'b1; m_per[i] = 1'b1; end
    m_lock = !pm; m_frz = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] op, input int sec, input bit wd,
                     input bit match, input bit sw, input string tag);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = SW'(sec);
    cmd_wdata = wd; pwd_match = match; sw_rst = sw;
    if (sw) foreach (m_dyn[i]) m_dyn[i] = 1'b1;
    else case (op)
      8'hE0: begin rd_q.push_back(m_dyn[sec]); rd_tag.push_back(tag); end
      8'hE2: begin rd_q.push_back(m_per[sec]); rd_tag.push_back(tag); end
      8'hA7: begin rd_q.push_back(m_lock); rd_tag.push_back(tag); end
      8'hE1: m_dyn[sec] = wd;
      8'hE3: if (m_lock) m_per[sec] = 1'b0;
      8'hE4: if (m_lock) foreach (m_per[i]) m_per[i] = 1'b1;
      8'hA6: begin m_lock = 1'b0; m_frz = 1'b1; end
      8'hE9: if (pwd_mode && match && !m_frz) m_lock = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0; sw_rst = 1'b0; pwd_match = 1'b0;
  endtask

  task automatic req(input int sec, input string tag);
    req_valid = 1'b1; req_sector = SW'(sec);
    vq.push_back(m_dyn[sec] && m_per[sec]); vq_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    power_on(1'b0);
    @(negedge clk);
    check(!rd_valid && !req_grant && !req_err, "R9 outputs idle after reset", rd_valid, 0);
    cmd(8'hE0, 3, 0, 0, 0, "R9 dyn bit after reset");
    cmd(8'hE2, 3, 0, 0, 0, "R9 per bit after reset");
    cmd(8'hA7, 0, 0, 0, 0, "R7 lock set in persistent mode");
    req(5, "R1 open sector granted");
    // R2 dynamic write/read
    cmd(8'hE1, 5, 0, 0, 0, "");
    cmd(8'hE0, 5, 0, 0, 0, "R2 dyn cleared");
    req(5, "R1 dyn-protected sector refused");
    cmd(8'hE1, 5, 1, 0, 0, "");
    req(5, "R2 dyn reopened granted");
    // R3 single persistent clear
    cmd(8'hE3, 7, 0, 0, 0, "");
    cmd(8'hE2, 7, 0, 0, 0, "R3 per bit cleared");
    cmd(8'hE2, 6, 0, 0, 0, "R3 neighbour untouched");
    req(7, "R1 per-protected sector refused");
    cmd(8'hE3, N-1, 0, 0, 0, "");
    cmd(8'hE2, N-1, 0, 0, 0, "R3 top sector cleared");
    // R4 bulk set
    cmd(8'hE4, 0, 0, 0, 0, "");
    cmd(8'hE2, 7, 0, 0, 0, "R4 bulk set sector 7");
    cmd(8'hE2, N-1, 0, 0, 0, "R4 bulk set top sector");
    // R5/R6 freeze
    cmd(8'hE3, 9, 0, 0, 0, "");
    cmd(8'hA6, 0, 0, 0, 0, "");
    cmd(8'hA7, 0, 0, 0, 0, "R6 lock cleared");
    cmd(8'hE4, 0, 0, 0, 0, "");
    cmd(8'hE2, 9, 0, 0, 0, "R5 bulk set ignored when frozen");
    cmd(8'hE3, 10, 0, 0, 0, "");
    cmd(8'hE2, 10, 0, 0, 0, "R5 clear ignored when frozen");
    cmd(8'hE9, 0, 0, 1, 0, "");
    cmd(8'hA7, 0, 0, 0, 0, "R6 lock not rearmed by unlock");
    // R8 software reset
    cmd(8'hE1, 4, 0, 0, 0, "");
    cmd(8'hE1, 8, 0, 0, 1, "");
    cmd(8'hE0, 4, 0, 0, 0, "R8 dyn reopened by soft reset");
    cmd(8'hE0, 8, 0, 0, 0, "R8 same-cycle command ignored");
    cmd(8'hA7, 0, 0, 0, 0, "R8 lock kept");
    cmd(8'hE2, 9, 0, 0, 0, "R8 per bit kept");
    req(9, "R8 per protection survives soft reset");
    // R10 unknown opcode
    cmd(8'h55, 2, 0, 0, 0, "");
    cmd(8'hE0, 2, 0, 0, 0, "R10 unknown opcode no effect");
    // R7 password mode
    power_on(1'b1);
    cmd(8'hA7, 0, 0, 0, 0, "R7 lock clear in password mode");
    cmd(8'hE3, 1, 0, 0, 0, "");
    cmd(8'hE2, 1, 0, 0, 0, "R7 per frozen until unlock");
    cmd(8'hE9, 0, 0, 0, 0, "");
    cmd(8'hA7, 0, 0, 0, 0, "R7 mismatched unlock ignored");
    cmd(8'hE9, 0, 0, 1, 0, "");
    cmd(8'hA7, 0, 0, 0, 0, "R7 matched unlock sets lock");
    cmd(8'hE3, 1, 0, 0, 0, "");
    cmd(8'hE2, 1, 0, 0, 0, "R7 per clear after unlock");
    cmd(8'hA6, 0, 0, 0, 0, "");
    cmd(8'hE9, 0, 0, 1, 0, "");
    cmd(8'hA7, 0, 0, 0, 0, "R6 password unlock after freeze ignored");
    repeat (3) @(negedge clk);
    check(rd_q.size() == 0 && vq.size() == 0, "R10 all responses arrived",
          rd_q.size() + vq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule